// File: doc/BRIEF.md
# UART baud clock generator

This block produces the timing strobes for an asynchronous serial transmit and receive engine. It works in two stages. A prescaler divides the main clock by a selectable power of two, or follows an external clock pin instead. Its result is a single-cycle base-clock enable. An 8-bit programmable counter then counts those base enables and emits a baud enable once per divisor period. Both outputs are clock-enable pulses in the main clock domain, not derived clocks.

Software reaches two byte registers through a small write/read port. The select register (address 0) holds a 4-bit code in bits 3..0; bits 7..4 always read as zero. Codes 0 to 10 divide by 2^code. Code 11 picks the external pin when the `EXT_EN` parameter is 1. Codes 12 to 15 are illegal, and so is 11 when `EXT_EN` is 0. The select may only change while `uart_en` is low. The divisor register (address 1) can be written at any time. A run-control state machine has two states, `ST_OFF` and `ST_RUN`. Transition OFF→RUN is taken at a clock edge that samples `uart_en` high. Transition RUN→OFF is taken at an edge that samples it low. Counting happens only in `ST_RUN` while `uart_en` is high. Otherwise both counters are held at zero.

Top module: `baud_clkgen`

## Requirements
- R1: After reset the select register reads 0x00, the divisor reads 0xFF, `sel_err` is 0 and neither tick output is asserted.
- R2: A read at address 0 returns {4'b0000, select code}. A read at address 1 returns the raw divisor byte. On a select write only bits 3..0 of the data are kept.
- R3: With code k in 0..10, `base_tick` pulses for one cycle every 2^k cycles. The first pulse falls in the 2^k-th cycle after the clock edge that first samples `uart_en` high.
- R4: With code 11 and `EXT_EN`=1, every rising edge of `ext_clk` yields exactly one single-cycle `base_tick` after a two-flop synchronizer.
- R5: A select write of an illegal code (12..15, or 11 when `EXT_EN`=0) while `uart_en` is 0 leaves the register unchanged and sets `sel_err`. `sel_err` then stays 1 until reset.
- R6: A select write while `uart_en` is 1 is ignored entirely. The register keeps its value and `sel_err` is not set, even for an illegal code.
- R7: The effective divisor is E = max(divisor, 4). `baud_tick` is asserted only together with `base_tick`, on every E-th base tick.
- R8: While `uart_en` is 0 no tick is produced and both counters return to zero. After re-enabling, the first baud tick falls in cycle E·2^k after the enabling edge.
- R9: Divisor writes are accepted whether `uart_en` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = clock select, 1 = divisor |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| uart_en | input | 1 | Serial unit enable |
| ext_clk | input | 1 | External base clock pin (asynchronous) |
| sel_err | output | 1 | Sticky flag: illegal select code written |
| base_tick | output | 1 | Base-clock enable pulse |
| baud_tick | output | 1 | Baud-rate enable pulse |

## Verification
Two things can land in the same cycle. The first pair is a baud tick and the base tick it must ride on: each run measures the positions of both pulses from the enabling edge onward, and any baud pulse without a base pulse is counted as a failure. The second pair is write protection and code rejection: an illegal select code is written while `uart_en` is high. The bench then checks at the read port and at `sel_err` that protection wins: the register is unchanged and no error is recorded. Later, the same kind of code is written while the unit is disabled, and the bench checks that the flag does get set.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int          SEL_W    = 4;
    localparam int          MAX_EXP  = 10;
    localparam logic [3:0]  CODE_EXT = 4'd11;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_t;

    function automatic logic code_ok(input logic [SEL_W-1:0] c, input bit ext_en);
        return (int'(c) <= MAX_EXP) || (ext_en && (c == CODE_EXT));
    endfunction
endpackage

// File: rtl/bcg_regs.sv
module bcg_regs
    import bcg_pkg::*;
#(
    parameter int         DIV_W   = 8,
    parameter bit         EXT_EN  = 1'b1,
    parameter logic [7:0] DIV_RST = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 addr,
    input  logic [7:0]           wdata,
    input  logic                 uart_en,
    output logic [7:0]           rdata,
    output logic [SEL_W-1:0]     sel_code,
    output logic [DIV_W-1:0]     div_val,
    output logic                 sel_err
);
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_q;
    logic             err_q;
    logic [SEL_W-1:0] wcode;

    assign wcode = wdata[SEL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else if (wr && !addr && !uart_en) begin
            if (code_ok(wcode, EXT_EN)) begin
                sel_q <= wcode;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_RST[DIV_W-1:0];
        end else if (wr && addr) begin
            div_q <= wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[DIV_W-1:0] = div_q;
        end else begin
            rdata[SEL_W-1:0] = sel_q;
        end
    end

    assign sel_code = sel_q;
    assign div_val  = div_q;
    assign sel_err  = err_q;

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        uart_en |=> $stable(sel_q)); // R6
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(sel_q, EXT_EN)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R5
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import bcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uart_en,
    output logic active
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (uart_en)  state_d = ST_RUN;
            ST_RUN: if (!uart_en) state_d = ST_OFF;
        endcase
    end

    always_comb begin
        active = 1'b0;
        unique case (state_q)
            ST_OFF: active = 1'b0;
            ST_RUN: active = uart_en;
        endcase
    end
endmodule

// File: rtl/bcg_prescaler.sv
module bcg_prescaler
    import bcg_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             ext_clk,
    output logic             base_tick
);
    logic [MAX_EXP-1:0] cnt_q;
    logic [MAX_EXP-1:0] mask;
    logic               ext_rise;
    logic               use_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < MAX_EXP; i++) begin
            mask[i] = (i < int'(sel_code));
        end
    end

    generate
        if (EXT_EN) begin : g_ext
            logic [2:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= {sync_q[1:0], ext_clk};
                end
            end
            assign ext_rise = sync_q[1] & ~sync_q[2];
        end else begin : g_noext
            logic unused_ext;
            assign unused_ext = ext_clk;
            assign ext_rise   = 1'b0;
        end
    endgenerate

    assign use_ext   = EXT_EN && (sel_code == CODE_EXT);
    assign base_tick = active && (use_ext ? ext_rise : ((cnt_q & mask) == mask));

    AST_PRE_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0)); // R8
    AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && base_tick) |=> !base_tick); // R4
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider #(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div_val,
    output logic             baud_tick
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] dcnt_q;
    logic [DIV_W-1:0] eff;
    logic             last;

    assign eff  = (div_val < MIN_V) ? MIN_V : div_val;
    assign last = (dcnt_q >= eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else if (!active) begin
            dcnt_q <= '0;
        end else if (base_tick) begin
            dcnt_q <= last ? '0 : dcnt_q + 1'b1;
        end
    end

    assign baud_tick = base_tick && last;

    AST_DIV_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (dcnt_q == '0)); // R8
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import bcg_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 4,
    parameter bit EXT_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       uart_en,
    input  logic       ext_clk,
    output logic       sel_err,
    output logic       base_tick,
    output logic       baud_tick
);
    logic [SEL_W-1:0] sel_code;
    logic [DIV_W-1:0] div_val;
    logic             active;

    bcg_regs #(.DIV_W(DIV_W), .EXT_EN(EXT_EN), .DIV_RST(8'hFF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .uart_en(uart_en), .rdata(reg_rdata), .sel_code(sel_code),
        .div_val(div_val), .sel_err(sel_err)
    );

    bcg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .active(active)
    );

    bcg_prescaler #(.EXT_EN(EXT_EN)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(active), .sel_code(sel_code),
        .ext_clk(ext_clk), .base_tick(base_tick)
    );

    bcg_divider #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .active(active), .base_tick(base_tick),
        .div_val(div_val), .baud_tick(baud_tick)
    );

    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en |-> (!base_tick && !baud_tick)); // R8
    AST_BAUD_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> base_tick); // R7
endmodule

// File: tb/baud_clkgen_test.sv
`timescale 1ns/1ps
module baud_clkgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       uart_en = 1'b0;
    logic       ext_clk = 1'b0;
    logic       sel_err;
    logic       base_tick;
    logic       baud_tick;

    int ncmp = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    baud_clkgen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uart_en(uart_en),
        .ext_clk(ext_clk), .sel_err(sel_err), .base_tick(base_tick),
        .baud_tick(baud_tick)
    );

    function automatic int exp_eff(input int d);
        return (d < 4) ? 4 : d;
    endfunction

    function automatic int exp_period(input int k);
        return 1 << k;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        ncmp++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        uart_en = v;
    endtask

    task automatic measure(input int k, input int d);
        int eff, per, limit, first_base, nbase, nbaud, b1, b2, lone;
        set_en(1'b0);
        repeat (2) @(negedge clk);
        wr_reg(1'b0, 8'(k));
        wr_reg(1'b1, 8'(d));
        eff = exp_eff(d); per = exp_period(k);
        limit = 2 * eff * per + 10;
        first_base = -1; nbase = 0; nbaud = 0; b1 = -1; b2 = -1; lone = 0;
        set_en(1'b1);
        @(posedge clk);
        for (int n = 1; n <= limit; n++) begin
            #1;
            if (base_tick) begin
                if (first_base < 0) first_base = n;
                nbase++;
            end
            if (baud_tick) begin
                if (!base_tick) lone++;
                nbaud++;
                if (nbaud == 1) b1 = n;
                if (nbaud == 2) b2 = n;
            end
            if (nbaud == 2) break;
            @(posedge clk);
        end
        check($sformatf("R3 first base tick k=%0d", k), first_base, per);
        check($sformatf("R8 first baud tick k=%0d d=%0d", k, d), b1, eff * per);
        check($sformatf("R7 second baud tick k=%0d d=%0d", k, d), b2, 2 * eff * per);
        check($sformatf("R7 base ticks per two bauds d=%0d", d), nbase, 2 * eff);
        check("R7 baud without base", lone, 0);
        set_en(1'b0);
    endtask

    task automatic count_cycles(input int n, inout int nb, inout int nd);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (base_tick) nb++;
            if (baud_tick) nd++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        ncmp++; nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        int v, nb, nd, rk, rdv;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, v); check("R1 select reset", v, 0);
        rd_reg(1'b1, v); check("R1 divisor reset", v, 255);
        check("R1 err reset", int'(sel_err), 0);
        check("R1 ticks reset", int'(base_tick | baud_tick), 0);

        // R2 upper bits dropped
        wr_reg(1'b0, 8'hA5);
        rd_reg(1'b0, v); check("R2 select readback", v, 5);

        // R6 writes while enabled ignored, protection wins over rejection
        wr_reg(1'b0, 8'h02);
        set_en(1'b1);
        wr_reg(1'b0, 8'h05);
        rd_reg(1'b0, v); check("R6 select frozen", v, 2);
        wr_reg(1'b0, 8'h0E);
        rd_reg(1'b0, v); check("R6 illegal while enabled frozen", v, 2);
        check("R6 no error while enabled", int'(sel_err), 0);
        // R9 divisor write while enabled
        wr_reg(1'b1, 8'h09);
        rd_reg(1'b1, v); check("R9 divisor write enabled", v, 9);
        set_en(1'b0);

        // R8 silence while disabled
        nb = 0; nd = 0;
        count_cycles(40, nb, nd);
        check("R8 no base tick disabled", nb, 0);
        check("R8 no baud tick disabled", nd, 0);

        // directed corners
        measure(0, 0);
        measure(0, 3);
        measure(0, 255);
        measure(10, 4);
        measure(1, 5);

        // constrained random
        for (int t = 0; t < 12; t++) begin
            rk = int'($urandom_range(0, 6));
            rdv = int'($urandom_range(0, 40));
            measure(rk, rdv);
        end

        // R4 external clock
        set_en(1'b0);
        ext_clk = 1'b0;
        wr_reg(1'b0, 8'd11);
        rd_reg(1'b0, v); check("R4 ext code accepted", v, 11);
        wr_reg(1'b1, 8'd0);
        set_en(1'b1);
        nb = 0; nd = 0;
        count_cycles(4, nb, nd);
        for (int e = 0; e < 8; e++) begin
            ext_clk = 1'b1;
            count_cycles(5, nb, nd);
            ext_clk = 1'b0;
            count_cycles(5, nb, nd);
        end
        count_cycles(8, nb, nd);
        check("R4 base ticks per ext edge", nb, 8);
        check("R7 baud ticks from ext", nd, 2);

        // R8 drop enable mid-run
        wr_reg(1'b0, 8'd0);
        set_en(1'b0);
        wr_reg(1'b0, 8'd0);
        set_en(1'b1);
        nb = 0; nd = 0;
        count_cycles(10, nb, nd);
        set_en(1'b0);
        nb = 0; nd = 0;
        count_cycles(20, nb, nd);
        check("R8 ticks stop on disable", nb + nd, 0);

        // R5 illegal codes rejected while disabled, sticky flag
        wr_reg(1'b0, 8'd2);
        wr_reg(1'b0, 8'd12);
        rd_reg(1'b0, v); check("R5 code 12 rejected", v, 2);
        check("R5 err set", int'(sel_err), 1);
        wr_reg(1'b0, 8'd15);
        rd_reg(1'b0, v); check("R5 code 15 rejected", v, 2);
        wr_reg(1'b0, 8'd3);
        rd_reg(1'b0, v); check("R5 legal after error", v, 3);
        check("R5 err sticky", int'(sel_err), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule